// File: doc/BRIEF.md
# Period and Pulse-Width Capture Unit

This block measures a digital input signal in clock cycles. A free-running timebase counter restarts on every qualifying rising edge of the input. At that rising edge the elapsed count is stored as the period. At the following falling edge the count since the rising edge is stored as the high time. Both results land in two capture channels. A single mapping select decides whether channel 0 holds the period and channel 1 the high time, or the reverse.

The input first passes through an optional polarity inversion. It then goes through a multi-flop synchronizer and an edge detector. With inversion on, the unit measures the low time of the raw signal instead of the high time. Each channel has its own capture enable and its own sticky done flag. The unit also keeps a sticky error flag, set when a capture overwrites a channel whose done flag is still set, and a sticky overflow flag, set when the timebase saturates before the next rising edge. Each flag is cleared by driving a 1 on its clear input for one cycle.

Top module: `pwc_capture`

## Requirements
- R1: After reset both capture values are 0, and the done, overflow and error flags are all 0.
- R2: The first qualifying rising edge after reset restarts the timebase and does not capture anything. No done flag is set and both capture values stay 0.
- R3: With map_sel = 0, the number of clock cycles between two qualifying rising edges is stored in channel 0 at the second edge. The number of cycles from a qualifying rising edge to the next falling edge is stored in channel 1 at that falling edge.
- R4: With map_sel = 1, the period is stored in channel 1 and the high time in channel 0, with the same values as in R3.
- R5: With evt_invert = 1, the input is inverted before synchronization. The period is then measured between falling edges of evt_in, and the pulse width is the time evt_in stays low.
- R6: A channel whose bit in cap_en is 0 does not capture. Its value and its done bit stay unchanged, and it never raises the error flag.
- R7: A capture sets the channel's bit in cap_done. Driving done_clr bit i to 1 for one cycle clears cap_done bit i only, when no capture to that channel happens in the same cycle.
- R8: A capture into a channel whose done bit is already set still overwrites the value and sets err_flag. err_clr = 1 for one cycle clears err_flag.
- R9: If the timebase reaches all ones (65535 for the default 16-bit width) before the next qualifying rising edge, ovf_flag is set and the timebase holds at all ones. A period captured in that state reads all ones. ovf_clr = 1 for one cycle clears ovf_flag.
- R10: An input change made just after a clock edge updates the affected capture value and done bit at the third rising clock edge that follows. The done bit is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timebase advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_in | input | 1 | Signal to be measured, asynchronous to clk |
| evt_invert | input | 1 | 1 inverts evt_in before synchronization |
| map_sel | input | 1 | 0: period to channel 0 and width to channel 1; 1: swapped |
| cap_en | input | 2 | Per-channel capture enable, bit i for channel i |
| done_clr | input | 2 | Write-1 clear for cap_done bits |
| ovf_clr | input | 1 | Write-1 clear for ovf_flag |
| err_clr | input | 1 | Write-1 clear for err_flag |
| cap0_val | output | 16 | Channel 0 capture value |
| cap1_val | output | 16 | Channel 1 capture value |
| cap_done | output | 2 | Sticky capture-done flags, bit i for channel i |
| ovf_flag | output | 1 | Sticky timebase overflow flag |
| err_flag | output | 1 | Sticky overwrite error flag |

## Verification
The assertions assume that map_sel, evt_invert and cap_en change only while the input is idle, so that a period and the width that follows it are routed under the same settings. They also assume that the clear inputs are single-cycle pulses and that evt_in holds each level for at least two clock cycles, so the synchronizer sees every edge. The bench changes configuration only in reset or between measurements, and it drives evt_in and the clears on the falling clock edge. Every level it drives lasts several cycles, and it keeps measured intervals short except in the one overflow scenario.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Mapping of measurement results onto the two capture channels.
  typedef enum logic {
    MAP_PER0_WID1 = 1'b0,
    MAP_PER1_WID0 = 1'b1
  } map_e;

  localparam int NUM_CH = 2;

  // Edge strobes produced by the synchronizer stage.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync
  import pwc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  din,
  input  logic  invert,
  output edge_t edges
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         hist_q, hist_d;
  logic         pol_in;

  assign pol_in = din ^ invert;

  // Next-state: shift the polarity-corrected input through the chain.
  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = pol_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[TOP-1:0], pol_in};
    end
  endgenerate

  always_comb hist_d = sync_q[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  always_comb begin
    edges.rise = sync_q[TOP] & ~hist_q;
    edges.fall = ~sync_q[TOP] & hist_q;
  end

  // R10: a rising strobe lasts one cycle and is not repeated at the next edge.
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    edges.rise |=> !edges.rise);

  // R10: the same holds for falling strobes.
  a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    edges.fall |=> !edges.fall);

endmodule

// File: rtl/pwc_timebase.sv
module pwc_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] tb,
  output logic         ovf_evt
);

  localparam logic [W-1:0] TB_MAX    = '1;
  localparam logic [W-1:0] TB_ONE    = W'(1);
  localparam logic [W-1:0] TB_MAX_M1 = TB_MAX - TB_ONE;

  logic [W-1:0] tb_q, tb_d;
  logic         at_max;
  logic         cnt_en;

  assign at_max  = (tb_q == TB_MAX);
  assign cnt_en  = ~at_max;
  assign ovf_evt = (tb_q == TB_MAX_M1) & ~restart;

  // Next-state: the restart cycle itself counts as the first cycle.
  always_comb begin
    tb_d = tb_q;
    if (restart) begin
      tb_d = TB_ONE;
    end else if (cnt_en) begin
      tb_d = tb_q + TB_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else begin
      tb_q <= tb_d;
    end
  end

  assign tb = tb_q;

  // R3: a restart always leaves the timebase at one.
  a_r3_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tb == TB_ONE));

  // R9: once saturated, the timebase holds until restarted.
  a_r9_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tb == TB_MAX && !restart) |=> (tb == TB_MAX));

  // R9: the overflow strobe is followed by a saturated timebase.
  a_r9_ovf_reaches_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (tb == TB_MAX));

endmodule

// File: rtl/pwc_cap_chan.sv
module pwc_cap_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] tb_val,
  output logic [W-1:0] val,
  output logic         done,
  output logic         overrun
);

  logic [W-1:0] val_q, val_d;
  logic         done_q, done_d;
  logic         take;

  assign take    = stb & en;
  assign overrun = take & done_q;

  // Next-state: a capture wins over a clear in the same cycle.
  always_comb begin
    val_d  = val_q;
    done_d = done_q;
    if (take) begin
      val_d  = tb_val;
      done_d = 1'b1;
    end else if (clr) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      done_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      done_q <= done_d;
    end
  end

  assign val  = val_q;
  assign done = done_q;

  // R3: a capture stores the timebase value seen in the strobe cycle.
  a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> (val == $past(tb_val)));

  // R7: a capture leaves the done bit set.
  a_r7_capture_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> done);

  // R7: a clear with no capture in that cycle empties the done bit.
  a_r7_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(stb && en)) |=> !done);

  // R6: a disabled channel keeps its value.
  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(val));

endmodule

// File: rtl/pwc_capture.sv
module pwc_capture
  import pwc_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_in,
  input  logic            evt_invert,
  input  logic            map_sel,
  input  logic [1:0]      cap_en,
  input  logic [1:0]      done_clr,
  input  logic            ovf_clr,
  input  logic            err_clr,
  output logic [TB_W-1:0] cap0_val,
  output logic [TB_W-1:0] cap1_val,
  output logic [1:0]      cap_done,
  output logic            ovf_flag,
  output logic            err_flag
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  // Input conditioning.
  edge_t edges;

  pwc_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .din    (evt_in),
    .invert (evt_invert),
    .edges  (edges)
  );

  // Armed after the first qualifying rising edge.
  logic primed_q, primed_d;

  always_comb primed_d = primed_q | edges.rise;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
    end else begin
      primed_q <= primed_d;
    end
  end

  // Timebase.
  logic [TB_W-1:0] tb_val;
  logic            ovf_evt;

  pwc_timebase #(
    .W (TB_W)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_ni),
    .restart (edges.rise),
    .tb      (tb_val),
    .ovf_evt (ovf_evt)
  );

  // Route measurement strobes onto channels.
  logic            per_stb, wid_stb;
  map_e            map;
  logic [1:0]      ch_stb;
  logic [1:0]      ch_overrun;
  logic [TB_W-1:0] ch_val [NUM_CH];

  assign map     = map_e'(map_sel);
  assign per_stb = edges.rise & primed_q;
  assign wid_stb = edges.fall & primed_q;

  always_comb begin
    if (map == MAP_PER0_WID1) begin
      ch_stb = {wid_stb, per_stb};
    end else begin
      ch_stb = {per_stb, wid_stb};
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pwc_cap_chan #(
        .W (TB_W)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_ni),
        .stb     (ch_stb[i]),
        .en      (cap_en[i]),
        .clr     (done_clr[i]),
        .tb_val  (tb_val),
        .val     (ch_val[i]),
        .done    (cap_done[i]),
        .overrun (ch_overrun[i])
      );
    end
  endgenerate

  assign cap0_val = ch_val[0];
  assign cap1_val = ch_val[1];

  // Sticky status flags; a new event wins over a clear.
  logic ovf_q, ovf_d;
  logic err_q, err_d;

  always_comb begin
    ovf_d = (ovf_q & ~ovf_clr) | ovf_evt;
    err_d = (err_q & ~err_clr) | (|ch_overrun);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      err_q <= err_d;
    end
  end

  assign ovf_flag = ovf_q;
  assign err_flag = err_q;

  // R8: an overrun in any channel raises the error flag.
  a_r8_overrun_sets_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (|ch_overrun) |=> err_flag);

  // R9: the overflow strobe from the timebase raises the overflow flag.
  a_r9_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_evt |=> ovf_flag);

  // R2: the arming edge never changes a done bit.
  a_r2_arming_no_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    (edges.rise && !primed_q && done_clr == 2'b00) |=> $stable(cap_done));

  // R6: a disabled channel never contributes an overrun.
  a_r6_disabled_no_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (!err_flag && (cap_en == 2'b00) && !(|ch_overrun)) |=> !err_flag);

  // R3: with the default mapping a period strobe lands in channel 0.
  a_r3_map0_period: assert property (@(posedge clk) disable iff (!rst_ni)
    (map_sel == 1'b0 && per_stb && cap_en[0]) |=> cap_done[0]);

  // R4: with the swapped mapping a period strobe lands in channel 1.
  a_r4_map1_period: assert property (@(posedge clk) disable iff (!rst_ni)
    (map_sel == 1'b1 && per_stb && cap_en[1]) |=> cap_done[1]);

endmodule

// File: tb/sim_pwc_capture.sv
module sim_pwc_capture;

  logic        clk;
  logic        rst_n;
  logic        evt_in;
  logic        evt_invert;
  logic        map_sel;
  logic [1:0]  cap_en;
  logic [1:0]  done_clr;
  logic        ovf_clr;
  logic        err_clr;
  logic [15:0] cap0_val;
  logic [15:0] cap1_val;
  logic [1:0]  cap_done;
  logic        ovf_flag;
  logic        err_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  pwc_capture u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .evt_invert (evt_invert),
    .map_sel    (map_sel),
    .cap_en     (cap_en),
    .done_clr   (done_clr),
    .ovf_clr    (ovf_clr),
    .err_clr    (err_clr),
    .cap0_val   (cap0_val),
    .cap1_val   (cap1_val),
    .cap_done   (cap_done),
    .ovf_flag   (ovf_flag),
    .err_flag   (err_flag)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic inv, input logic [1:0] en, input logic lvl);
    rst_n = 1'b0; evt_in = lvl; evt_invert = inv; map_sel = m; cap_en = en;
    done_clr = 2'b00; ovf_clr = 1'b0; err_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    chk("R1 cap0", cap0_val, 0);
    chk("R1 cap1", cap1_val, 0);
    chk("R1 done", cap_done, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 err", err_flag, 0);
  endtask

  task automatic t_arming;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(6);
    chk("R2 done", cap_done, 0);
    chk("R2 cap0", cap0_val, 0);
    chk("R2 cap1", cap1_val, 0);
  endtask

  task automatic t_map0;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(3); evt_in = 1'b0; step(7);
    evt_in = 1'b1; step(4);
    chk("R3 period ch0", cap0_val, 10);
    chk("R3 width ch1", cap1_val, 3);
    chk("R7 done both", cap_done, 2'b11);
    done_clr = 2'b01; step(1); done_clr = 2'b00;
    chk("R7 clear ch0 only", cap_done, 2'b10);
    done_clr = 2'b10; step(1); done_clr = 2'b00;
    chk("R7 clear ch1", cap_done, 2'b00);
    // High time is 4 + 1 + 1 = 6 cycles, low 14.
    evt_in = 1'b0; step(14); evt_in = 1'b1; step(4);
    chk("R3 period2 ch0", cap0_val, 20);
    chk("R3 width2 ch1", cap1_val, 6);
    chk("R3 no err", err_flag, 0);
  endtask

  task automatic t_map1;
    do_reset(1'b1, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(3); evt_in = 1'b0; step(7);
    evt_in = 1'b1; step(4);
    chk("R4 period ch1", cap1_val, 10);
    chk("R4 width ch0", cap0_val, 3);
  endtask

  task automatic t_invert;
    do_reset(1'b0, 1'b1, 2'b11, 1'b1);
    evt_in = 1'b0; step(6); evt_in = 1'b1; step(5);
    evt_in = 1'b0; step(4);
    chk("R5 period ch0", cap0_val, 11);
    chk("R5 low time ch1", cap1_val, 6);
  endtask

  task automatic t_enable;
    do_reset(1'b0, 1'b0, 2'b01, 1'b0);
    evt_in = 1'b1; step(3); evt_in = 1'b0; step(7);
    evt_in = 1'b1; step(4);
    chk("R6 ch1 value held", cap1_val, 0);
    chk("R6 done only ch0", cap_done, 2'b01);
    chk("R6 ch0 captured", cap0_val, 10);
    done_clr = 2'b01; step(1); done_clr = 2'b00;
    evt_in = 1'b0; step(6);
    chk("R6 no err from disabled ch1", err_flag, 0);
    chk("R6 ch1 still held", cap1_val, 0);
  endtask

  task automatic t_overrun;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(3); evt_in = 1'b0; step(7);
    evt_in = 1'b1; step(2); evt_in = 1'b0; step(6);
    evt_in = 1'b1; step(4);
    chk("R8 ch0 overwritten", cap0_val, 8);
    chk("R8 ch1 overwritten", cap1_val, 2);
    chk("R8 err set", err_flag, 1);
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    chk("R8 err cleared", err_flag, 0);
  endtask

  task automatic t_overflow;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(2); evt_in = 1'b0; step(65600);
    chk("R9 ovf set", ovf_flag, 1);
    chk("R9 width ch1", cap1_val, 2);
    evt_in = 1'b1; step(4);
    chk("R9 saturated period", cap0_val, 16'hFFFF);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R9 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_latency;
    do_reset(1'b0, 1'b0, 2'b11, 1'b0);
    evt_in = 1'b1; step(4);
    evt_in = 1'b0; step(2);
    chk("R10 not yet after two edges", cap_done[1], 0);
    step(1);
    chk("R10 done after third edge", cap_done[1], 1);
    chk("R10 width", cap1_val, 4);
  endtask

  initial begin
    t_reset;
    t_arming;
    t_map0;
    t_map1;
    t_invert;
    t_enable;
    t_overrun;
    t_overflow;
    t_latency;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule